// File: doc/BRIEF.md
# Sticky Error Status Register Bank

This block keeps the error status of a multi-channel temperature and voltage monitor. Each measurement cycle it receives the results of the limit comparisons: an over-limit flag and an under-limit flag for each of six channels, and an open/short diode flag for each of four remote-diode channels. Any flag that is seen sets a sticky bit. The bits sit in three detail registers: over-limit, under-limit and diode fault. An interrupt summary register ORs each detail register down to one bit.

A plain read port exposes all four registers to the bus logic. A read of a detail register clears only the bits whose condition is no longer present. A condition that persists survives the read. Reading the summary register never clears anything, so summary bits drop only after the detail bits under them have been cleared. Remote channels 1 to 3 can be switched to voltage inputs. In that mode their diode-fault flag is masked.

Top module: `err_status_bank`

## Requirements
- R1: After reset every register reads 00h.
- R2: A flag presented with `meas_valid` high sets its sticky bit on the next clock, and the bit stays set until it is cleared by a read. In the over-limit register (address 24h) and the under-limit register (address 25h), `hi_cmp[i]` and `lo_cmp[i]` map to bit i: bit 0 is the internal channel, bits 1 to 4 are remote channels 1 to 4, and bit 5 is voltage channel 4.
- R3: The diode fault register is at address 26h. `diode_flt[i]`, which is remote channel i+1, maps to bit i+1 (bits 1 to 4).
- R4: The summary register is at address 23h. Bit 2 is the OR of the over-limit register, bit 1 is the OR of the under-limit register and bit 0 is the OR of the diode fault register. Bits 7 to 3 are zero.
- R5: A read of the summary register changes no status bit.
- R6: A read of a detail register clears each set bit whose latest sampled condition (the last value given with `meas_valid`, taken before the read clock edge) is inactive. A bit whose condition is still active stays set.
- R7: A bit set by a flag in the same cycle as a clearing read of its register stays set.
- R8: While `volt_sel[k]` is high (k = 0..2, for remote channel k+1), `diode_flt[k]` neither sets nor holds the fault bit for that channel.
- R9: Bits 7 to 6 of the over-limit and under-limit registers read zero. Diode fault bits 0 and 7 to 5 read zero. Any unmapped address reads 00h.
- R10: `rd_data` and `rd_valid` are registered. They present, one cycle after `rd_en`, the register value from before any clear caused by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | Comparison results valid this cycle |
| hi_cmp | input | 6 | Over-limit flags per channel |
| lo_cmp | input | 6 | Under-limit flags per channel |
| diode_flt | input | 4 | Diode fault flags, remote channels 1 to 4 |
| volt_sel | input | 3 | Remote channels 1 to 3 used as voltage inputs |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
The bench attacks the clear-on-read rule from several angles:
- A persistent condition read repeatedly must survive each read. A design that cleared unconditionally would return zero on the second read.
- A condition that went inactive must be cleared by exactly one detail read, and the summary bit must fall with it. A design that cleared on a summary read would lose the bits early.
- A new flag coinciding with the clearing read must remain. A design that gave the clear priority would drop that event.
- A fault flag on a channel in voltage mode must leave the fault register empty.
- Long random traffic compares every read against a behavioural model.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int HL_W    = 6;  // over/under-limit channels
  localparam int FLT_N   = 4;  // remote diode channels
  localparam int VSEL_N  = 3;  // remote channels that may be voltage inputs
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 8'h23;
  localparam logic [ADDR_W-1:0] A_HIGH    = 8'h24;
  localparam logic [ADDR_W-1:0] A_LOW     = 8'h25;
  localparam logic [ADDR_W-1:0] A_FAULT   = 8'h26;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SUM, SEL_HIGH, SEL_LOW, SEL_FAULT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      A_SUMMARY: return SEL_SUM;
      A_HIGH:    return SEL_HIGH;
      A_LOW:     return SEL_LOW;
      A_FAULT:   return SEL_FAULT;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/err_fault_gate.sv
module err_fault_gate #(
  parameter int N_CH   = 4,
  parameter int N_VSEL = 3
) (
  input  logic [N_CH-1:0]   raw_flt,
  input  logic [N_VSEL-1:0] vsel,
  output logic [N_CH-1:0]   eff_flt
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (i < N_VSEL) begin : g_maskable
      // a channel measuring voltage has no diode to fault
      assign eff_flt[i] = raw_flt[i] & ~vsel[i];
    end else begin : g_fixed
      assign eff_flt[i] = raw_flt[i];
    end
  end
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         meas_valid,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  output logic [W-1:0] status
);
  logic [W-1:0] active;   // last sampled condition per bit
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  assign set_v = meas_valid ? cond : '0;
  assign clr_v = rd_clr ? ~active : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      status <= '0;
    end else begin
      if (meas_valid) active <= cond;
      // set wins over clear for a coincident new event
      status <= (status & ~clr_v) | set_v;
    end
  end

  assert_set_sticks_R7: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && |cond) |=> ((status & $past(cond)) == $past(cond)));

  assert_persist_kept_R6: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ((status & $past(status & active)) == $past(status & active)));

  assert_no_clear_wo_read_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/err_read_mux.sv
module err_read_mux
  import err_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [HL_W-1:0]   hi_st,
  input  logic [HL_W-1:0]   lo_st,
  input  logic [FLT_N-1:0]  flt_st,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_SUM:   word[2:0] = {|hi_st, |lo_st, |flt_st};
      SEL_HIGH:  word[HL_W-1:0] = hi_st;
      SEL_LOW:   word[HL_W-1:0] = lo_st;
      SEL_FAULT: word[FLT_N:1] = flt_st;
      default:   word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word;
    end
  end

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[DATA_W-1:HL_W] == '0));
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
  import err_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [HL_W-1:0]   hi_cmp,
  input  logic [HL_W-1:0]   lo_cmp,
  input  logic [FLT_N-1:0]  diode_flt,
  input  logic [VSEL_N-1:0] volt_sel,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  reg_sel_e          sel;
  logic [FLT_N-1:0]  flt_eff;
  logic [HL_W-1:0]   hi_st, lo_st;
  logic [FLT_N-1:0]  flt_st;

  assign sel = decode_addr(rd_addr);

  err_fault_gate #(.N_CH(FLT_N), .N_VSEL(VSEL_N)) u_gate (
    .raw_flt(diode_flt), .vsel(volt_sel), .eff_flt(flt_eff)
  );

  err_sticky_bank #(.W(HL_W)) u_high (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .cond(hi_cmp),
    .rd_clr(rd_en && sel == SEL_HIGH), .status(hi_st)
  );

  err_sticky_bank #(.W(HL_W)) u_low (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .cond(lo_cmp),
    .rd_clr(rd_en && sel == SEL_LOW), .status(lo_st)
  );

  err_sticky_bank #(.W(FLT_N)) u_fault (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .cond(flt_eff),
    .rd_clr(rd_en && sel == SEL_FAULT), .status(flt_st)
  );

  err_read_mux u_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
    .hi_st(hi_st), .lo_st(lo_st), .flt_st(flt_st),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assert_summary_read_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_SUM) |=>
      (((hi_st & $past(hi_st)) == $past(hi_st)) &&
       ((lo_st & $past(lo_st)) == $past(lo_st)) &&
       ((flt_st & $past(flt_st)) == $past(flt_st))));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/err_status_bank_test.sv
module err_status_bank_test;
  logic clk = 0, rst = 1;
  logic meas_valid = 0;
  logic [5:0] hi_cmp = 0, lo_cmp = 0;
  logic [3:0] diode_flt = 0;
  logic [2:0] volt_sel = 0;
  logic rd_en = 0;
  logic [7:0] rd_addr = 0;
  logic rd_valid;
  logic [7:0] rd_data;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural model state
  int mh = 0, ml = 0, mf = 0, ah = 0, al = 0, af = 0;

  always #5 clk = ~clk;

  err_status_bank uut (.*);

  function automatic int model_read(int addr);
    case (addr)
      'h23: return ((mh != 0) << 2) | ((ml != 0) << 1) | (mf != 0);
      'h24: return mh;
      'h25: return ml;
      'h26: return mf << 1;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit mv, input int h, input int l, input int f,
                      input int vs, input bit rd, input int addr, input string tag);
    int exp_d, feff;
    @(negedge clk);
    meas_valid = mv; hi_cmp = h[5:0]; lo_cmp = l[5:0]; diode_flt = f[3:0];
    volt_sel = vs[2:0]; rd_en = rd; rd_addr = addr[7:0];
    exp_d = rd ? model_read(addr) : 0;
    feff = f & ~(vs & 7) & 'hF;
    if (rd && addr == 'h24) mh = mh & ah;
    if (rd && addr == 'h25) ml = ml & al;
    if (rd && addr == 'h26) mf = mf & af;
    if (mv) begin
      mh |= h & 'h3F; ml |= l & 'h3F; mf |= feff;
      ah = h & 'h3F; al = l & 'h3F; af = feff;
    end
    @(posedge clk); #1;
    if (rd) begin
      n_tests++;
      if (!rd_valid || rd_data != exp_d[7:0]) begin
        n_fail++;
        $display("FAIL %s addr=%0h actual=%0h/v%0b expected=%0h", tag, addr,
                 rd_data, rd_valid, exp_d);
      end
    end
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, "idle"); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    for (int a = 'h23; a <= 'h26; a++) step(0, 0, 0, 0, 0, 1, a, "R1");
    // R2 bit positions, R4 summary
    step(1, 'h21, 'h00, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 'h24, "R2");
    step(0, 0, 0, 0, 0, 1, 'h23, "R4");
    // R5 summary read twice keeps bits
    step(0, 0, 0, 0, 0, 1, 'h23, "R5");
    step(0, 0, 0, 0, 0, 1, 'h24, "R5");
    // R6 persistent condition survives read
    step(0, 0, 0, 0, 0, 1, 'h24, "R6");
    // condition goes away, read clears once
    step(1, 0, 'h12, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 'h24, "R6");
    step(0, 0, 0, 0, 0, 1, 'h24, "R6");
    step(0, 0, 0, 0, 0, 1, 'h23, "R6");
    // R7 event coincident with clearing read
    step(1, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 'h01, 0, 0, 1, 'h25, "R7");
    step(0, 0, 0, 0, 0, 1, 'h25, "R7");
    // R3 fault positions
    step(1, 0, 0, 'hF, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 'h26, "R3");
    step(1, 0, 0, 0, 0, 1, 'h26, "R3");
    step(0, 0, 0, 0, 0, 1, 'h26, "R3");
    // R8 voltage mode masks fault
    step(1, 0, 0, 'hF, 7, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 'h26, "R8");
    step(1, 0, 0, 0, 0, 1, 'h26, "R8");
    step(0, 0, 0, 0, 0, 1, 'h26, "R8");
    // R9 unused bits and unmapped addresses
    step(1, 'h3F, 'h3F, 'hF, 0, 0, 0, "R9");
    for (int a = 'h20; a <= 'h28; a++) step(0, 0, 0, 0, 0, 1, a, "R9");
    step(0, 0, 0, 0, 0, 1, 'hFF, "R9");
    // R10 random traffic against model
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = 'h23 + $urandom_range(0, 4);
      step($urandom_range(0, 2) == 0, $urandom & 'h3F, $urandom & 'h3F,
           $urandom & 'hF, $urandom & 7, $urandom_range(0, 1), a, "R10");
    end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule